// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution Unit

This block performs the AES byte substitution in either direction without storing any table. A byte is carried into the composite field GF((2^4)^2) by a linear change of basis. It is inverted there using only GF(2^4) multiply, square and invert logic, and it is carried back by the inverse change of basis. The affine step of the cipher sits on the output side for forward substitution and on the input side for inverse substitution. A single inversion datapath therefore serves both directions.

Bytes arrive and leave on valid/ready streams. A transfer happens on a rising clock edge when valid and ready are both high. An upstream source must hold `in_data` and `in_mode` steady while `in_valid` is high and `in_ready` is low. The output holds `out_data` steady while `out_valid` is high and `out_ready` is low.

The parameter `PIPE` selects one of two forms. With `PIPE = 0` the unit is purely combinational and passes the handshake straight through. With `PIPE = 1` a register sits between the basis change and the inversion, and that register is also the stream's single storage slot.

Top module: `aes_cf_sbox`

## Requirements
- R1: With `in_mode = 0` (forward), `out_data` equals the AES forward substitution of `in_data`. That value is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map in which each output bit i is the XOR of input bits i, i+4, i+5, i+6, i+7 (indices mod 8) and bit i of 0x63.
- R2: With `in_mode = 1` (inverse), `out_data` equals the AES inverse substitution of `in_data`, so that forward(`out_data`) equals `in_data`.
- R3: Zero, which has no inverse, is treated as its own inverse: forward of 0x00 gives 0x63, and inverse of 0x63 gives 0x00.
- R4: For every byte x, applying the inverse substitution to the forward result of x returns x.
- R5: With `PIPE = 1`, a byte accepted on a clock edge is presented with `out_valid` high right after that edge, so the latency is exactly one cycle.
- R6: With `PIPE = 0`, the unit is combinational: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_data` corresponds to the current input within the same cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` remain unchanged and `in_ready` is low.
- R8: During reset (`rst_n` low), `out_valid` is low when `PIPE = 1`.
- R9: While `out_ready` is high, `in_ready` is high. A full stage therefore drains and refills on the same edge without a bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Unit can accept a byte |
| in_mode | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_data | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Substituted byte |

## Verification
A wrong basis matrix, a wrong subfield constant or a faulty GF(2^4) operation changes the value for most bytes. It therefore shows up within a few bytes of any sweep in either mode, as soon as the first affected byte reaches `out_data` one cycle later. A mode bit that is not carried alongside the data through the register gives the wrong direction on the first transfer after a mode change. Fault in the storage slot shows under back-pressure: either the held byte changes, or a new byte is accepted while the old one waits. Either effect is visible on the cycle right after the stall begins.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;

  localparam logic [7:0] FWD_AFFINE_C = 8'h63;
  localparam logic [7:0] INV_AFFINE_C = 8'h05;

  typedef logic [7:0][7:0] basis_t;

  // GF(2^4) product modulo x^4 + x + 1
  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = 4'h0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  // a^14 is the inverse for nonzero a, and 0 for a = 0
  function automatic logic [3:0] gf16_inv(input logic [3:0] a);
    logic [3:0] p2, p4, p8;
    p2 = gf16_mul(a, a);
    p4 = gf16_mul(p2, p2);
    p8 = gf16_mul(p4, p4);
    return gf16_mul(gf16_mul(p8, p4), p2);
  endfunction

  // smallest lambda making y^2 + y + lambda irreducible over GF(2^4)
  function automatic logic [3:0] pick_lambda();
    logic [3:0] res;
    logic       done, hit;
    res  = 4'h0;
    done = 1'b0;
    for (int l = 1; l < 16; l++) begin
      hit = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf16_mul(4'(t), 4'(t)) ^ 4'(t)) == 4'(l)) hit = 1'b1;
      if (!hit && !done) begin
        res  = 4'(l);
        done = 1'b1;
      end
    end
    return res;
  endfunction

  localparam logic [3:0] LAMBDA = pick_lambda();

  // product in GF((2^4)^2), element = {hi, lo} meaning hi*y + lo, y^2 = y + lambda
  function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh, hl, lh, ll;
    hh = gf16_mul(a[7:4], b[7:4]);
    hl = gf16_mul(a[7:4], b[3:0]);
    lh = gf16_mul(a[3:0], b[7:4]);
    ll = gf16_mul(a[3:0], b[3:0]);
    return {hh ^ hl ^ lh, gf16_mul(hh, LAMBDA) ^ ll};
  endfunction

  function automatic logic [7:0] apply_basis(input basis_t cols, input logic [7:0] v);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++)
      if (v[i]) r = r ^ cols[i];
    return r;
  endfunction

  // columns: images of alpha^i, alpha a root of x^8+x^4+x^3+x+1 found in the tower field
  function automatic basis_t fwd_basis();
    basis_t     cols;
    logic [7:0] pw [9];
    logic       done;
    cols = '0;
    done = 1'b0;
    for (int c = 2; c < 256; c++) begin
      pw[0] = 8'h01;
      for (int k = 1; k < 9; k++) pw[k] = cf_mul(pw[k-1], 8'(c));
      if (!done && ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00)) begin
        for (int k = 0; k < 8; k++) cols[k] = pw[k];
        done = 1'b1;
      end
    end
    return cols;
  endfunction

  function automatic basis_t back_basis(input basis_t fwd);
    basis_t cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int v = 0; v < 256; v++)
        if (apply_basis(fwd, 8'(v)) == (8'h01 << j)) cols[j] = 8'(v);
    return cols;
  endfunction

  localparam basis_t TO_CF   = fwd_basis();
  localparam basis_t FROM_CF = back_basis(TO_CF);

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

endpackage

// File: rtl/cf_linmap.sv
module cf_linmap
  import aes_cf_pkg::*;
#(
  parameter basis_t COLS = '0
) (
  input  logic [7:0] a,
  output logic [7:0] y
);
  logic [7:0] term [8];

  for (genvar i = 0; i < 8; i++) begin : g_col
    assign term[i] = a[i] ? COLS[i] : 8'h00;
  end

  always_comb begin
    y = 8'h00;
    for (int i = 0; i < 8; i++) y = y ^ term[i];
  end
endmodule

// File: rtl/cf_inverter.sv
module cf_inverter
  import aes_cf_pkg::*;
(
  input  logic [7:0] x,
  output logic [7:0] y
);
  logic [3:0] hi, lo, hi_sq, norm, norm_inv, sum;

  assign hi       = x[7:4];
  assign lo       = x[3:0];
  assign sum      = hi ^ lo;
  assign hi_sq    = gf16_mul(hi, hi);
  // norm = lambda*hi^2 + hi*lo + lo^2
  assign norm     = gf16_mul(hi_sq, LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_mul(lo, lo);
  assign norm_inv = gf16_inv(norm);
  assign y        = {gf16_mul(hi, norm_inv), gf16_mul(sum, norm_inv)};
endmodule

// File: rtl/aes_cf_front.sv
module aes_cf_front
  import aes_cf_pkg::*;
(
  input  logic       mode,
  input  logic [7:0] din,
  output logic [7:0] cf
);
  logic [7:0] unaff, pre;

  assign unaff = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ INV_AFFINE_C;
  assign pre   = mode ? unaff : din;

  cf_linmap #(.COLS(TO_CF)) u_map (.a(pre), .y(cf));
endmodule

// File: rtl/aes_cf_back.sv
module aes_cf_back
  import aes_cf_pkg::*;
(
  input  logic       mode,
  input  logic [7:0] cf_inv,
  output logic [7:0] dout
);
  logic [7:0] plain, aff;

  cf_linmap #(.COLS(FROM_CF)) u_unmap (.a(cf_inv), .y(plain));

  assign aff  = plain ^ rotl8(plain, 1) ^ rotl8(plain, 2) ^ rotl8(plain, 3)
              ^ rotl8(plain, 4) ^ FWD_AFFINE_C;
  assign dout = mode ? plain : aff;
endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox #(
  parameter int PIPE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_mode,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic [7:0] cf_in, cf_mid, cf_out;
  logic       mode_mid;

  aes_cf_front u_front (.mode(in_mode), .din(in_data), .cf(cf_in));

  if (PIPE != 0) begin : g_pipe
    logic       v_q;
    logic [7:0] cf_q;
    logic       mode_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        v_q <= 1'b0;
      else if (in_ready) v_q <= in_valid;
    end

    always_ff @(posedge clk) begin
      if (in_ready && in_valid) begin
        cf_q   <= cf_in;
        mode_q <= in_mode;
      end
    end

    assign cf_mid    = cf_q;
    assign mode_mid  = mode_q;
    assign out_valid = v_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign cf_mid    = cf_in;
    assign mode_mid  = in_mode;
    assign out_valid = in_valid;
  end

  cf_inverter u_inv (.x(cf_mid), .y(cf_out));

  aes_cf_back u_back (.mode(mode_mid), .cf_inv(cf_out), .dout(out_data));
endmodule

// File: rtl/aes_cf_sbox_chk.sv
module aes_cf_sbox_chk #(
  parameter int PIPE = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_mode,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R9

  if (PIPE != 0) begin : g_seq
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R5

    AST_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_mode && in_data == 8'h00 |=> out_data == 8'h63); // R3

    AST_ZERO_INV: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_mode && in_data == 8'h63 |=> out_data == 8'h00); // R3
  end else begin : g_cmb
    AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid); // R6

    AST_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_mode && in_data == 8'h00 |-> out_data == 8'h63); // R3
  end
endmodule

bind aes_cf_sbox aes_cf_sbox_chk #(.PIPE(PIPE)) u_chk (.*);

// File: tb/test_aes_cf_sbox.sv
module test_aes_cf_sbox;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_mode, out_ready, out_ready_c;
  logic [7:0] in_data;
  logic       in_ready, out_valid, in_ready_c, out_valid_c;
  logic [7:0] out_data, out_data_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] fwd_ref [256];
  logic [7:0] inv_ref [256];
  logic [7:0] got_fwd [256];

  always #4 clk = ~clk;

  aes_cf_sbox #(.PIPE(1)) i_aes_cf_sbox (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  aes_cf_sbox #(.PIPE(0)) i_aes_cf_sbox_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid_c),
    .out_ready(out_ready_c), .out_data(out_data_c));

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= s;
      s = s[7] ? ((s << 1) ^ 8'h1B) : (s << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h01;
    logic [7:0] o;
    for (int i = 0; i < 254; i++) inv = gmul(inv, x);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 256; v++) begin
      fwd_ref[v] = ref_sbox(8'(v));
      inv_ref[fwd_ref[v]] = 8'(v);
    end
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = 8'h00;
    out_ready = 1'b1; out_ready_c = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: combinational handshake follows downstream ready
    out_ready_c = 1'b0; #1;
    check(in_ready_c == 1'b0, "R6", in_ready_c, 0);
    out_ready_c = 1'b1;

    // R1 / R2 sweep, one byte per cycle, R5 one-cycle latency, R9 no bubble
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] exp;
        exp = (m == 0) ? fwd_ref[v] : inv_ref[v];
        in_valid = 1'b1; in_mode = m[0]; in_data = 8'(v);
        #1;
        check(out_valid_c && out_data_c == exp, "R6", out_data_c, exp);
        check(in_ready == 1'b1, "R9", in_ready, 1);
        @(negedge clk);
        check(out_valid == 1'b1, "R5", out_valid, 1);
        check(out_data == exp, (m == 0) ? "R1" : "R2", out_data, exp);
        if (m == 0) got_fwd[v] = out_data;
        if (m == 0 && v == 0) check(out_data == 8'h63, "R3", out_data, 8'h63);
        if (m == 1 && v == 8'h63) check(out_data == 8'h00, "R3", out_data, 0);
      end
    end

    // R4: inverse undoes forward for every byte
    for (int v = 0; v < 256; v++) begin
      in_valid = 1'b1; in_mode = 1'b1; in_data = got_fwd[v];
      @(negedge clk);
      check(out_data == 8'(v), "R4", out_data, v);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5", out_valid, 0);

    // R7: back-pressure holds the stored byte and blocks the input
    out_ready = 1'b0;
    in_valid = 1'b1; in_mode = 1'b0; in_data = 8'h53;
    @(negedge clk);
    in_data = 8'hA7; in_mode = 1'b1;
    repeat (3) begin
      #1;
      check(in_ready == 1'b0, "R7", in_ready, 0);
      check(out_valid && out_data == fwd_ref[8'h53], "R7", out_data, fwd_ref[8'h53]);
      @(negedge clk);
    end
    // R9: drain and fill on the same edge
    out_ready = 1'b1; #1;
    check(in_ready == 1'b1, "R9", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == inv_ref[8'hA7], "R9", out_data, inv_ref[8'hA7]);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", out_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule